// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block gives a host a single 32-bit command word for reaching PHY management registers. The host writes the word with an opcode, a PHY address, a register address and (for a write) sixteen data bits. The block then runs one clause-22 management frame on MDC/MDIO and flags completion in a ready bit of the same word. After a read frame, the sixteen bits returned by the PHY replace the low half of the word.

MDC is produced from the system clock by a parameterized divider and stays low between frames. The block drives MDIO through a data output plus an output-enable, and it samples the MDIO input on MDC rising edges. Each finished frame also raises a single-cycle completion pulse, meant for an interrupt status register.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word reads 0x1000_0000 (ready bit 28 set, all other bits 0), MDC is low, the output-enable is low and the completion pulse is low.
- R2: A host write while ready is 1 is accepted: ready reads 0 from the next clock, and bits 27:26 (opcode), 25:21 (PHY address) and 20:16 (register address) read back as written.
- R3: Every frame presents 64 bits MSB first, one bit per MDC period. The bits are 32 ones, then start 01, the opcode, the 5-bit PHY address and the 5-bit register address.
- R4: For opcode 01 (write), the turnaround is driven as 10 and is followed by the 16 write-data bits from bits 15:0. The output-enable is high for all 64 bits.
- R5: For opcode 10 (read), the output-enable is low for the last 18 bits (turnaround and data). MDIO input is sampled at the MDC rising edge of each of the 16 data bits. At completion those bits, MSB first, replace bits 15:0 of the command word.
- R6: Ready returns to 1 at the end of the 64th MDC period. The completion output is high for exactly that one clock, and ready and completion rise together.
- R7: A host write while ready is 0 is ignored: the frame in progress and the fields that read back are unchanged.
- R8: MDC has a period of 2*CLK_DIV system clocks while a frame runs, gives exactly 64 rising edges per frame, and is held low when idle.
- R9: Bits 31:29 of the command word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe for the command word |
| wrData | input | 32 | Command word written by the host |
| cmdReg | output | 32 | Command word readback: ready, fields, data |
| doneEvt | output | 1 | One-clock pulse when a frame completes |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO data driven by the block |
| mdioOe | output | 1 | MDIO output-enable (1 = block drives) |
| mdioIn | input | 1 | MDIO data sampled from the line |

## Verification
The assertions check on every cycle that:
- idle means MDC low and the line released;
- an accepted write drops ready;
- the address and opcode fields stay frozen while busy;
- completion is a lone pulse that coincides with ready rising;
- the top bits read zero.

Only the bench scenarios can show frame content, because that needs the serial stream rebuilt at MDC edges:
- the preamble and the field order;
- the write turnaround;
- the release window on reads;
- the captured read data, and the MDC period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_START   = 46;
  localparam int DATA_START = 48;
  localparam int DATA_W     = 16;

  // command word field positions (host visible)
  localparam int READY_BIT = 28;
  localparam int OP_LSB    = 26;
  localparam int PHY_LSB   = 21;
  localparam int REG_LSB   = 16;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef struct packed {
    logic load;    // capture command, build frame
    logic shift;   // advance to next frame bit
    logic sample;  // capture one read data bit
    logic finish;  // frame over, publish read data
  } ctrlStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         isRead,
  output logic         ready,
  output logic         mdc,
  output logic         mdioOe,
  output logic         doneEvt,
  output ctrlStrobes_t stb
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t            stateQ;
  logic [DIV_W-1:0]  divCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              mdcQ;
  logic              doneQ;
  logic              halfTick;
  logic              riseTick;
  logic              fallTick;
  logic              lastBit;

  generate
    if (CLK_DIV == 1) begin : g_nodiv
      assign halfTick = (stateQ == ST_RUN);
    end else begin : g_div
      assign halfTick = (stateQ == ST_RUN) && (divCnt == DIV_LAST);
    end
  endgenerate

  assign riseTick = halfTick && !mdcQ;
  assign fallTick = halfTick && mdcQ;
  assign lastBit  = (bitIdx == IDX_LAST);

  always_comb begin
    stb.load   = wrEn && (stateQ == ST_IDLE);
    stb.shift  = fallTick && !lastBit;
    stb.sample = riseTick && isRead && (bitIdx >= IDX_W'(DATA_START));
    stb.finish = fallTick && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= stb.finish;
      if (stateQ == ST_IDLE) begin
        divCnt <= '0;
        bitIdx <= '0;
        mdcQ   <= 1'b0;
        if (stb.load) stateQ <= ST_RUN;
      end else begin
        if (halfTick) begin
          divCnt <= '0;
          mdcQ   <= !mdcQ;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        if (stb.shift)  bitIdx <= bitIdx + 1'b1;
        if (stb.finish) stateQ <= ST_IDLE;
      end
    end
  end

  assign ready   = (stateQ == ST_IDLE);
  assign mdc     = mdcQ;
  assign doneEvt = doneQ;
  assign mdioOe  = (stateQ == ST_RUN) && !(isRead && (bitIdx >= IDX_W'(TA_START)));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  wrData,
  input  ctrlStrobes_t stb,
  input  logic         mdioIn,
  output logic         isRead,
  output logic         mdioOut,
  output logic [27:0]  fields
);
  logic [1:0]            opQ;
  logic [4:0]            phyQ;
  logic [4:0]            regQ;
  logic [DATA_W-1:0]     dataQ;
  logic [DATA_W-1:0]     rdQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [FRAME_BITS-1:0] frameNew;
  logic [1:0]            taNew;
  logic [1:0]            opNew;

  assign opNew = wrData[OP_LSB +: 2];
  assign taNew = (opNew == OP_READ) ? 2'b11 : 2'b10;
  assign frameNew = {{PRE_BITS{1'b1}}, 2'b01, opNew,
                     wrData[PHY_LSB +: 5], wrData[REG_LSB +: 5],
                     taNew, wrData[DATA_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= '0;
      phyQ   <= '0;
      regQ   <= '0;
      dataQ  <= '0;
      rdQ    <= '0;
      shiftQ <= '0;
    end else begin
      if (stb.load) begin
        opQ    <= opNew;
        phyQ   <= wrData[PHY_LSB +: 5];
        regQ   <= wrData[REG_LSB +: 5];
        dataQ  <= wrData[DATA_W-1:0];
        shiftQ <= frameNew;
      end else if (stb.shift) begin
        shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
      end
      if (stb.sample) rdQ <= {rdQ[DATA_W-2:0], mdioIn};
      if (stb.finish && isRead) dataQ <= rdQ;
    end
  end

  assign isRead  = (opQ == OP_READ);
  assign mdioOut = shiftQ[FRAME_BITS-1];
  assign fields  = {opQ, phyQ, regQ, dataQ};
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] cmdReg,
  output logic        doneEvt,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  ctrlStrobes_t stb;
  logic         isRead;
  logic         ready;
  logic [27:0]  fields;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .isRead(isRead),
    .ready(ready), .mdc(mdc), .mdioOe(mdioOe), .doneEvt(doneEvt), .stb(stb)
  );

  mdio_dp u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stb(stb), .mdioIn(mdioIn),
    .isRead(isRead), .mdioOut(mdioOut), .fields(fields)
  );

  assign cmdReg = {3'b000, ready, fields};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] cmdReg,
  input logic        doneEvt,
  input logic        mdc,
  input logic        mdioOe
);
  // R1 R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReg[28] |-> (!mdc && !mdioOe));

  // R2
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg[28] && wrEn) |=> !cmdReg[28]);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> !doneEvt);

  // R6
  done_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReg[28]) |-> doneEvt);

  // R6
  done_implies_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> cmdReg[28]);

  // R7
  busy_fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReg[28] && $past(!cmdReg[28])) |-> $stable(cmdReg[27:16]));

  // R9
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReg[31:29] == 3'b000);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdReg(cmdReg),
  .doneEvt(doneEvt), .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int NVEC = 4;
  // {command word, data returned by the PHY model}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0420_1234, 16'h0000},
    {32'h0BE2_FFFF, 16'hA5C3},
    {32'h055F_FFFF, 16'h0000},
    {32'h0811_0000, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] cmdReg;
  logic        doneEvt;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  int riseCnt = 0;
  int doneCnt = 0;
  int cycCnt = 0;
  int riseCyc0 = 0;
  int riseCyc1 = 0;
  logic [63:0] capOut;
  logic [63:0] capOe;
  logic [15:0] phyData = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cmdReg(cmdReg),
    .doneEvt(doneEvt), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge clk) begin
    cycCnt++;
    if (doneEvt) doneCnt++;
  end

  // PHY model: records the line at every MDC rise
  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capOut[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]  = mdioOe;
    end
    if (riseCnt == 0) riseCyc0 = cycCnt;
    if (riseCnt == 1) riseCyc1 = cycCnt;
    riseCnt++;
  end

  // PHY model: presents its data after the falling edge
  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt < 64) mdioIn = phyData[15-(riseCnt-48)];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic [31:0] c);
    @(negedge clk);
    riseCnt = 0;
    doneCnt = 0;
    wrEn = 1'b1;
    wrData = c;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitReady();
    int n = 0;
    while (!cmdReg[28] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, "R6 timeout", 64'(n), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [63:0] expFrame(input logic [31:0] c);
    logic [1:0] ta;
    ta = (c[27:26] == 2'b10) ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, c[27:26], c[25:21], c[20:16], ta, c[15:0]};
  endfunction

  task automatic runFrame(input logic [31:0] c, input logic [15:0] pd);
    logic [63:0] ef;
    logic [31:0] er;
    bit rd;
    rd = (c[27:26] == 2'b10);
    phyData = pd;
    ef = expFrame(c);
    startCmd(c);
    check(cmdReg[28] == 1'b0, "R2 ready clears", 64'(cmdReg[28]), 64'd0);
    check(cmdReg[27:16] == c[27:16], "R2 fields readback", 64'(cmdReg[27:16]), 64'(c[27:16]));
    waitReady();
    check(riseCnt == 64, "R8 64 MDC rises", 64'(riseCnt), 64'd64);
    check(doneCnt == 1, "R6 one done pulse", 64'(doneCnt), 64'd1);
    check(capOut[63:18] == ef[63:18], "R3 header bits", capOut, ef);
    if (rd) begin
      check(capOe == {{46{1'b1}}, 18'b0}, "R5 release window", capOe, {{46{1'b1}}, 18'b0});
      er = {3'b000, 1'b1, c[27:16], pd};
      check(cmdReg == er, "R5 read data", 64'(cmdReg), 64'(er));
    end else begin
      check(capOut[17:0] == ef[17:0], "R4 ta and data", 64'(capOut[17:0]), 64'(ef[17:0]));
      check(capOe == '1, "R4 driven throughout", capOe, '1);
      er = {3'b000, 1'b1, c[27:0]};
      check(cmdReg == er, "R2 write readback", 64'(cmdReg), 64'(er));
    end
    check(mdc == 1'b0 && mdioOe == 1'b0, "R8 idle low", 64'({mdc, mdioOe}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] ef;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmdReg == 32'h1000_0000, "R1 reset word", 64'(cmdReg), 64'h1000_0000);
    check(!mdc && !mdioOe && !doneEvt, "R1 reset outputs", 64'({mdc, mdioOe, doneEvt}), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) runFrame(VEC[i][47:16], VEC[i][15:0]);

    // R8 MDC period
    check(riseCyc1 - riseCyc0 == 2*DIV, "R8 MDC period", 64'(riseCyc1 - riseCyc0), 64'(2*DIV));

    // R7 write while busy is ignored
    phyData = 16'h0;
    startCmd(32'h0462_BEEF);
    repeat (200) @(negedge clk);
    wrEn = 1'b1;
    wrData = 32'h0BFF_0000;
    @(negedge clk);
    wrEn = 1'b0;
    check(cmdReg[27:16] == 12'h462 >> 0 ? cmdReg[27:16] == 32'h0462_BEEF >> 16 : 1'b0,
          "R7 fields kept", 64'(cmdReg[27:16]), 64'(32'h0462_BEEF >> 16));
    waitReady();
    ef = expFrame(32'h0462_BEEF);
    check(capOut == ef, "R7 frame unchanged", capOut, ef);
    check(doneCnt == 1, "R7 single completion", 64'(doneCnt), 64'd1);
    check(cmdReg == 32'h1462_BEEF, "R7 readback", 64'(cmdReg), 64'h1462_BEEF);

    // R9 upper bits written as ones still read zero
    runFrame(32'hE421_5A5A, 16'h0);
    check(cmdReg[31:29] == 3'b000, "R9 top bits zero", 64'(cmdReg[31:29]), 64'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule